// File: doc/BRIEF.md
# Two-Wire Slave Status and Interrupt Flags

This block keeps the status byte for the target side of a two-wire serial interface. A separate protocol engine reports events to it as single-cycle pulses: a byte finished, the own address was recognised, a stop condition was seen, a collision happened, a bus error happened, and an acknowledge bit was sampled. The block turns these pulses into sticky flags, two interrupt requests and a request to stretch the serial clock.

Software talks to the block over a simple register port. The port has three locations: status, data and command. Writing ones to the status location clears the matching sticky flags. Any read or write of the data location clears both interrupt flags as a side effect. A write of a valid command code to the command location does the same. The clock-stretch request follows the two interrupt flags directly, so the clock is held low until software has dealt with the pending event.

Top module: `i2c_slv_flags`

## Requirements
- R1: After reset `status_o` is 0x00, and `data_irq`, `addr_irq` and `scl_hold` are all low.
- R2: The `status_o` layout is, from bit 7 down: data flag, address/stop flag, clock hold, received acknowledge, collision, bus error, direction, address indicator.
- R3: The data flag (bit 7) sets on `byte_done` when `bus_err_det` is low. It also sets on `coll_det`. A `byte_done` that comes together with `bus_err_det` does not set it.
- R4: The address/stop flag (bit 6) sets on `addr_match` or on `stop_det`. In the same cycle, bit 1 loads `dir_in`, and bit 0 loads 1 for an address match or 0 for a stop alone.
- R5: A write to register address 0 clears whichever of bits 7, 6, 3 and 2 have a 1 in the write data. A 0 in those bits, and any value in bits 5, 4, 1 and 0, has no effect.
- R6: A read of register address 1, a write of register address 1, or a write of a valid command to register address 2 clears bits 7 and 6.
- R7: Bit 5 and `scl_hold` are high exactly when bit 7 or bit 6 is set.
- R8: When `ack_valid` is high, bit 4 loads `ack_bit` (0 = ACK, 1 = NACK) and holds it until the next `ack_valid`.
- R9: Bit 3 sets on `coll_det` and bit 2 sets on `bus_err_det`. Neither bit is cleared by the side-effect clears of R6.
- R10: `data_irq` is bit 7 AND `data_ien`. `addr_irq` is bit 6 AND `addr_ien`.
- R11: When a set event and a clear of the same flag arrive in one cycle, the flag ends up set.
- R12: A command is valid when write data bits [1:0] are 2'b10 or 2'b11 and bits [7:2] are zero. Any other command value leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_done | input | 1 | Byte transfer finished (pulse) |
| addr_match | input | 1 | Own address recognised (pulse) |
| stop_det | input | 1 | Stop condition seen (pulse) |
| coll_det | input | 1 | Collision detected (pulse) |
| bus_err_det | input | 1 | Bus error detected (pulse) |
| ack_valid | input | 1 | Acknowledge bit sampled (pulse) |
| ack_bit | input | 1 | Sampled acknowledge value, 1 = NACK |
| dir_in | input | 1 | Transfer direction at address time |
| data_ien | input | 1 | Data interrupt enable |
| addr_ien | input | 1 | Address/stop interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 data, 2 command |
| reg_wdata | input | 8 | Register write data |
| status_o | output | 8 | Status byte |
| data_irq | output | 1 | Data interrupt request |
| addr_irq | output | 1 | Address/stop interrupt request |
| scl_hold | output | 1 | Request to hold the serial clock low |

## Verification
The assertions check the following on every cycle:
- a completed byte, an address match or a stop sets its flag on the next edge;
- a clean data read clears both interrupt flags;
- a reserved command leaves the flags stable;
- the acknowledge bit follows its sample;
- the clock-stretch request never appears without a pending flag.

The bench scenarios cover what needs a sequence of events:
- the captured direction and address/stop indicator;
- the rule that read-only bits ignore writes;
- set winning over a clear that arrives in the same cycle;
- the interrupt enables gating the requests.

// File: rtl/i2c_slv_flags_pkg.sv
package i2c_slv_flags_pkg;
    localparam int DW     = 8;
    localparam int AW     = 2;
    localparam int CMD_W  = 2;
    localparam int FLAG_N = 4;

    // status bit positions
    localparam int POS_DIF   = 7;
    localparam int POS_APIF  = 6;
    localparam int POS_HOLD  = 5;
    localparam int POS_RXACK = 4;
    localparam int POS_COLL  = 3;
    localparam int POS_BERR  = 2;
    localparam int POS_DIR   = 1;
    localparam int POS_AP    = 0;

    // sticky flag slots, index order used by the flag array
    localparam int SLOT_DIF  = 0;
    localparam int SLOT_APIF = 1;
    localparam int SLOT_COLL = 2;
    localparam int SLOT_BERR = 3;

    typedef enum logic [AW-1:0] {
        SEL_STATUS = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_CMD    = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rxack;
        logic dir;
        logic ap;
    } aux_t;
endpackage

// File: rtl/i2c_slv_flag_cell.sv
module i2c_slv_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    // set has priority over clear
    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/i2c_slv_access_dec.sv
module i2c_slv_access_dec
    import i2c_slv_flags_pkg::*;
(
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [FLAG_N-1:0] w1c_o,
    output logic              auto_clr_o
);
    localparam int SLOT_POS [FLAG_N] = '{POS_DIF, POS_APIF, POS_COLL, POS_BERR};

    logic status_wr, data_acc, cmd_ok;

    always_comb begin
        status_wr  = reg_wr && (reg_sel_e'(reg_addr) == SEL_STATUS);
        data_acc   = (reg_wr || reg_rd) && (reg_sel_e'(reg_addr) == SEL_DATA);
        cmd_ok     = reg_wdata[CMD_W-1] && (reg_wdata[DW-1:CMD_W] == '0);
        auto_clr_o = data_acc
                   || (reg_wr && (reg_sel_e'(reg_addr) == SEL_CMD) && cmd_ok);
    end

    for (genvar g = 0; g < FLAG_N; g++) begin : g_w1c
        assign w1c_o[g] = status_wr && reg_wdata[SLOT_POS[g]];
    end
endmodule

// File: rtl/i2c_slv_flags.sv
module i2c_slv_flags
    import i2c_slv_flags_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_done,
    input  logic          addr_match,
    input  logic          stop_det,
    input  logic          coll_det,
    input  logic          bus_err_det,
    input  logic          ack_valid,
    input  logic          ack_bit,
    input  logic          dir_in,
    input  logic          data_ien,
    input  logic          addr_ien,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] status_o,
    output logic          data_irq,
    output logic          addr_irq,
    output logic          scl_hold
);
    logic [FLAG_N-1:0] w1c, set_vec, clr_vec, flags;
    logic              auto_clr;
    aux_t              aux_d, aux_q;

    i2c_slv_access_dec u_dec (
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .w1c_o      (w1c),
        .auto_clr_o (auto_clr)
    );

    always_comb begin
        set_vec[SLOT_DIF]  = (byte_done && !bus_err_det) || coll_det;
        set_vec[SLOT_APIF] = addr_match || stop_det;
        set_vec[SLOT_COLL] = coll_det;
        set_vec[SLOT_BERR] = bus_err_det;
        clr_vec[SLOT_DIF]  = w1c[SLOT_DIF]  || auto_clr;
        clr_vec[SLOT_APIF] = w1c[SLOT_APIF] || auto_clr;
        clr_vec[SLOT_COLL] = w1c[SLOT_COLL];
        clr_vec[SLOT_BERR] = w1c[SLOT_BERR];
    end

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        i2c_slv_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[g]),
            .clr_i  (clr_vec[g]),
            .flag_o (flags[g])
        );
    end

    // R4 R8 side fields
    always_comb begin
        aux_d = aux_q;
        if (ack_valid) aux_d.rxack = ack_bit;
        if (set_vec[SLOT_APIF]) begin
            aux_d.dir = dir_in;
            aux_d.ap  = addr_match;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) aux_q <= '0;
        else        aux_q <= aux_d;
    end

    always_comb begin
        status_o            = '0;
        status_o[POS_DIF]   = flags[SLOT_DIF];
        status_o[POS_APIF]  = flags[SLOT_APIF];
        status_o[POS_HOLD]  = flags[SLOT_DIF] || flags[SLOT_APIF];
        status_o[POS_RXACK] = aux_q.rxack;
        status_o[POS_COLL]  = flags[SLOT_COLL];
        status_o[POS_BERR]  = flags[SLOT_BERR];
        status_o[POS_DIR]   = aux_q.dir;
        status_o[POS_AP]    = aux_q.ap;
        scl_hold            = flags[SLOT_DIF] || flags[SLOT_APIF];
        data_irq            = flags[SLOT_DIF] && data_ien;
        addr_irq            = flags[SLOT_APIF] && addr_ien;
    end
endmodule

// File: rtl/i2c_slv_flags_chk.sv
module i2c_slv_flags_chk
    import i2c_slv_flags_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          byte_done,
    input logic          addr_match,
    input logic          stop_det,
    input logic          coll_det,
    input logic          bus_err_det,
    input logic          ack_valid,
    input logic          ack_bit,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] status_o,
    input logic          scl_hold
);
    logic no_set;
    assign no_set = !byte_done && !coll_det && !addr_match && !stop_det;

    // R3
    dif_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !bus_err_det) |=> status_o[POS_DIF]);

    // R4
    apif_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_match || stop_det) |=> status_o[POS_APIF]);

    // R6
    data_rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == AW'(1) && no_set)
        |=> (!status_o[POS_DIF] && !status_o[POS_APIF]));

    // R7
    hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> (status_o[POS_DIF] || status_o[POS_APIF]));

    // R8
    rxack_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> (status_o[POS_RXACK] == $past(ack_bit)));

    // R12
    bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && reg_addr == AW'(2) && !reg_wdata[1] && no_set)
        |=> $stable(status_o[POS_DIF:POS_APIF]));
endmodule

bind i2c_slv_flags i2c_slv_flags_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_done   (byte_done),
    .addr_match  (addr_match),
    .stop_det    (stop_det),
    .coll_det    (coll_det),
    .bus_err_det (bus_err_det),
    .ack_valid   (ack_valid),
    .ack_bit     (ack_bit),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .status_o    (status_o),
    .scl_hold    (scl_hold)
);

// File: tb/i2c_slv_flags_bench.sv
`timescale 1ns/1ps
module i2c_slv_flags_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_done = 0, addr_match = 0, stop_det = 0, coll_det = 0, bus_err_det = 0;
    logic ack_valid = 0, ack_bit = 0, dir_in = 0;
    logic data_ien = 1, addr_ien = 1, reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] status_o;
    logic data_irq, addr_irq, scl_hold;

    int compared = 0, mismatched = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    i2c_slv_flags u_i2c_slv_flags (.*);

    typedef struct packed {
        logic bd, am, sd, cd, be, av, ab, dr, wr, rd;
        logic [1:0] ad;
        logic [7:0] wd;
        logic [7:0] ex;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,8'hA0}, // R3 byte done
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,8'h00,8'h00}, // R6 data read
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,8'h00,8'h63}, // R4 address
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd1,8'h55,8'h03}, // R6 data write
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,8'h60}, // R4 stop
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'h80,8'h60}, // R5 clear unset bit
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'h40,8'h00}, // R5 clear apif
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,8'h10}, // R8 nack
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,8'hB8}, // R3 R9 collision
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'h88,8'h10}, // R5
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,8'h14}, // R3 R9 bus error
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'h04,8'h10}, // R5
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,8'h00}, // R8 ack
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,8'hA0}, // R3
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd2,8'h01,8'hA0}, // R12 reserved
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd2,8'h42,8'hA0}, // R12 upper bit
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd2,8'h02,8'h00}, // R6 command
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'h80,8'hA0}, // R11 vs w1c
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,8'h00,8'hA0}, // R11 vs read
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd2,8'h03,8'h00}, // R6 command
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,8'h61}, // R4 both
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'hFF,8'h01}  // R5 R2 read-only
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        byte_done = v.bd; addr_match = v.am; stop_det = v.sd; coll_det = v.cd;
        bus_err_det = v.be; ack_valid = v.av; ack_bit = v.ab; dir_in = v.dr;
        reg_wr = v.wr; reg_rd = v.rd; reg_addr = v.ad; reg_wdata = v.wd;
        @(posedge clk); #1;
        byte_done = 0; addr_match = 0; stop_det = 0; coll_det = 0; bus_err_det = 0;
        ack_valid = 0; reg_wr = 0; reg_rd = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 status", status_o, 8'h00);
        check("R1 outputs", {5'd0, data_irq, addr_irq, scl_hold}, 8'h00);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R1 after release", status_o, 8'h00);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check($sformatf("R2 vector %0d status", i), status_o, VEC[i].ex);
            check($sformatf("R7 R10 vector %0d outputs", i),
                  {5'd0, data_irq, addr_irq, scl_hold},
                  {5'd0, VEC[i].ex[7], VEC[i].ex[6], VEC[i].ex[7] | VEC[i].ex[6]});
        end

        // R10 enables gate the requests
        apply('{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'hC0,8'h00});
        data_ien = 0; addr_ien = 0;
        apply('{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,8'h00});
        check("R10 disabled", {6'd0, data_irq, addr_irq}, 8'h00);
        check("R7 hold while disabled", {7'd0, scl_hold}, 8'h01);
        @(negedge clk) data_ien = 1;
        #1 check("R10 data only", {6'd0, data_irq, addr_irq}, 8'h02);
        @(negedge clk) begin data_ien = 0; addr_ien = 1; end
        #1 check("R10 addr only", {6'd0, data_irq, addr_irq}, 8'h01);

        // R9 side-effect clears leave collision and bus error alone
        apply('{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,8'h00});
        apply('{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,8'h00,8'h00});
        check("R9 sticky after data read", status_o & 8'hCC, 8'h0C);

        // R1 reset mid-run
        @(negedge clk) rst_n = 1'b0;
        #1 check("R1 mid-run reset", status_o, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        summary();
    end
endmodule